// File: doc/BRIEF.md
# Half-Full Triggered Burst Drain Controller

This block is the reading side of a 32-bit wide FIFO that a video source fills. It watches the FIFO's active-low half-full flag. When that flag goes from inactive to active, the block empties a programmed number of words from the FIFO. The block drives the FIFO's active-low chip select and read strobe, and it captures each word into an output stream that has a valid qualifier. When the last word has been taken it raises a one-cycle completion pulse.

The transfer follows the pattern of a bus master that fetches through descriptors. Reads come in bursts of eight, and the bus rests for a fixed idle window after each burst. Every 32 reads form one descriptor chunk, and after each chunk the bus rests for a further reload window in which no word is taken. The programmed word count is clamped to half the FIFO depth. A transfer started by the half-full flag can therefore never read past the data that is known to be present.

Each read access keeps the strobes low for a number of cycles set by a programmable input. Both programmed values are captured when the transfer starts. A sticky error bit records any cycle in which the FIFO reports empty while a read access is in progress.

Top module: `hf_burst_drain`

## Requirements
- R1: During and right after a synchronous reset, cs_n and rd_n are 1, and out_valid, done, busy and underflow are 0.
- R2: A transfer starts only when the synchronised hf_n changes from 1 to 0, with exactly one transfer per such change. Holding hf_n low does not start another transfer, and a change to 0 while busy is 1 is ignored.
- R3: In every read access, cs_n and rd_n are low together for exactly N consecutive cycles. N is the value of access_cycles captured at the start of the transfer, and a captured value of 0 counts as 1.
- R4: Inside a burst, consecutive read accesses are separated by exactly one cycle with both strobes high.
- R5: After the 8th, 16th and 24th read of each 32-read chunk (a burst end that is not a chunk end), the strobes stay high for exactly 9 cycles before the next access.
- R6: After every 32nd read, the strobes stay high for exactly 9 + RELOAD_GAP cycles (13 with the default of 4) before the next access.
- R7: A transfer performs min(xfer_words, FIFO_DEPTH/2) read accesses. With the default depth of 16384 this is at most 8192 reads.
- R8: out_valid is 1 for one cycle right after each access ends. out_data then holds the rd_data value that was present during that access, and words appear in read order.
- R9: done is a one-cycle pulse that coincides with the out_valid of the last word. busy is 0 in the following cycle. When the programmed count is 0, done fires and no read takes place.
- R10: underflow becomes 1 if fifo_empty is 1 in any cycle in which rd_n is low. It then stays 1 until reset.
- R11: Whenever busy is 0, cs_n and rd_n are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hf_n | input | 1 | FIFO half-full flag, active low, asynchronous |
| fifo_empty | input | 1 | FIFO empty flag, active high |
| rd_data | input | 32 | FIFO read data |
| access_cycles | input | ACW (4) | Strobe-low cycles per read access (0 means 1) |
| xfer_words | input | WW (15) | Requested words per transfer |
| cs_n | output | 1 | FIFO chip select, active low |
| rd_n | output | 1 | FIFO read strobe, active low |
| out_valid | output | 1 | Captured word qualifier |
| out_data | output | 32 | Captured word |
| done | output | 1 | One-cycle transfer completion pulse |
| busy | output | 1 | Transfer in progress |
| underflow | output | 1 | Sticky read-while-empty error |

## Verification
The hardest condition to reach is the chunk-boundary reload window combined with the word-count clamp. Reaching it takes a transfer that runs through 256 full chunks and a request above the clamp. The stimulus therefore asks for 12000 words with the shortest access length and checks the length of every idle run against the position of the read that precedes it. A second hard case is a new half-full edge that arrives in the middle of a transfer. The bench releases and re-asserts hf_n while busy is high and then counts the completion pulses.

// File: rtl/drain_pkg.sv
package drain_pkg;

    localparam int DATA_W    = 32;
    localparam int BURST_LEN = 8;
    localparam int CHUNK_LEN = 32;
    localparam int BURST_GAP = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_RECOV,
        ST_GAP,
        ST_RELOAD,
        ST_DONE
    } drain_state_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } word_beat_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hf_edge_sync.sv
module hf_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hf_n_async,
    output logic start
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], hf_n_async};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign start = prev_q & ~sync_q[STAGES-1];

    // R2: a single falling edge yields a single start request
    assert_single_start_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

endmodule

// File: rtl/drain_sequencer.sv
module drain_sequencer
    import drain_pkg::*;
#(
    parameter int ACW        = 4,
    parameter int WW         = 15,
    parameter int CAP        = 8192,
    parameter int RELOAD_GAP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [ACW-1:0] access_cycles,
    input  logic [WW-1:0]  xfer_words,
    output logic          strobe,
    output logic          cap_en,
    output logic          done,
    output logic          busy
);
    localparam int POS_W   = $clog2(CHUNK_LEN);
    localparam int BEAT_W  = $clog2(BURST_LEN);
    localparam int GAP_MAX = max_int(BURST_GAP, RELOAD_GAP);
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam logic [WW-1:0]    CAP_V       = WW'(CAP);
    localparam logic [GAP_W-1:0] GAP_END     = GAP_W'(BURST_GAP - 1);
    localparam logic [GAP_W-1:0] RELOAD_END  = GAP_W'((RELOAD_GAP > 0) ? RELOAD_GAP - 1 : 0);

    drain_state_e       state_q, state_d;
    logic [ACW-1:0]     acc_len_q, acc_cnt_q, acc_new;
    logic [WW-1:0]      goal_q, words_q, goal_new;
    logic [POS_W-1:0]   pos_q;
    logic [GAP_W-1:0]   gap_q;
    logic               reload_q;
    logic               access_last, last_word, burst_end, chunk_end;
    logic               gap_last, reload_last;

    always_comb begin
        acc_new     = (access_cycles == '0) ? ACW'(1) : access_cycles;
        goal_new    = (xfer_words > CAP_V) ? CAP_V : xfer_words;
        access_last = (state_q == ST_READ) && (acc_cnt_q == acc_len_q - ACW'(1));
        last_word   = (words_q + WW'(1)) == goal_q;
        burst_end   = &pos_q[BEAT_W-1:0];
        chunk_end   = &pos_q;
        gap_last    = gap_q == GAP_END;
        reload_last = gap_q == RELOAD_END;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (goal_new == '0) ? ST_DONE : ST_READ;
            ST_READ: begin
                if (access_last) begin
                    if (last_word)      state_d = ST_DONE;
                    else if (burst_end) state_d = ST_GAP;
                    else                state_d = ST_RECOV;
                end
            end
            ST_RECOV:  state_d = ST_READ;
            ST_GAP: begin
                if (gap_last)
                    state_d = (reload_q && (RELOAD_GAP > 0)) ? ST_RELOAD : ST_READ;
            end
            ST_RELOAD: if (reload_last) state_d = ST_READ;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            acc_len_q <= ACW'(1);
            acc_cnt_q <= '0;
            goal_q    <= '0;
            words_q   <= '0;
            pos_q     <= '0;
            gap_q     <= '0;
            reload_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_GAP || state_q == ST_RELOAD) && state_d == state_q)
                gap_q <= gap_q + GAP_W'(1);
            else
                gap_q <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        acc_len_q <= acc_new;
                        goal_q    <= goal_new;
                        words_q   <= '0;
                        pos_q     <= '0;
                        acc_cnt_q <= '0;
                        reload_q  <= 1'b0;
                    end
                end
                ST_READ: begin
                    if (access_last) begin
                        acc_cnt_q <= '0;
                        words_q   <= words_q + WW'(1);
                        pos_q     <= pos_q + POS_W'(1);
                        reload_q  <= chunk_end;
                    end else begin
                        acc_cnt_q <= acc_cnt_q + ACW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign strobe = (state_q == ST_READ);
    assign cap_en = access_last;
    assign done   = (state_q == ST_DONE);
    assign busy   = (state_q != ST_IDLE);

    // R3: the access counter never runs past the captured access length
    assert_access_len_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READ) |-> (acc_cnt_q < acc_len_q));

    // R7: words read never exceed the clamped goal
    assert_word_cap_R7: assert property (@(posedge clk) disable iff (rst)
        (words_q <= goal_q) && (goal_q <= CAP_V));

    // R6: the reload window is only entered after a chunk boundary
    assert_reload_after_chunk_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RELOAD) |-> reload_q);

endmodule

// File: rtl/word_capture.sv
module word_capture
    import drain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic              strobe,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] rd_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              underflow
);
    word_beat_t beat_q;
    logic       und_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            und_q  <= 1'b0;
        end else begin
            beat_q.valid <= cap_en;
            if (cap_en) beat_q.data <= rd_data;
            if (strobe && fifo_empty) und_q <= 1'b1;
        end
    end

    assign out_valid = beat_q.valid;
    assign out_data  = beat_q.data;
    assign underflow = und_q;

    // R10: the error bit never clears outside reset
    assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        und_q |=> und_q);

    // R8: a valid word always follows a cycle with the read strobe active
    assert_valid_after_read_R8: assert property (@(posedge clk) disable iff (rst)
        beat_q.valid |-> $past(strobe));

endmodule

// File: rtl/hf_burst_drain.sv
module hf_burst_drain
    import drain_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16384,
    parameter int ACW         = 4,
    parameter int RELOAD_GAP  = 4,
    parameter int SYNC_STAGES = 2,
    parameter int WW          = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hf_n,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [ACW-1:0]    access_cycles,
    input  logic [WW-1:0]     xfer_words,
    output logic              cs_n,
    output logic              rd_n,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              done,
    output logic              busy,
    output logic              underflow
);
    localparam int CAP = FIFO_DEPTH / 2;

    logic start, strobe, cap_en;

    hf_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .hf_n_async (hf_n),
        .start      (start)
    );

    drain_sequencer #(
        .ACW        (ACW),
        .WW         (WW),
        .CAP        (CAP),
        .RELOAD_GAP (RELOAD_GAP)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .access_cycles (access_cycles),
        .xfer_words    (xfer_words),
        .strobe        (strobe),
        .cap_en        (cap_en),
        .done          (done),
        .busy          (busy)
    );

    word_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .cap_en     (cap_en),
        .strobe     (strobe),
        .fifo_empty (fifo_empty),
        .rd_data    (rd_data),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .underflow  (underflow)
    );

    assign cs_n = ~strobe;
    assign rd_n = ~strobe;

    // R11: strobes stay inactive while no transfer runs
    assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n && rd_n));

    // R9: completion is a single-cycle pulse and ends the busy period
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R2: a start request is only honoured while idle
    assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> busy || $past(done));

endmodule

// File: tb/hf_burst_drain_bench.sv
module hf_burst_drain_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ACW = 4;
    localparam int WW  = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hf_n = 1'b1;
    logic          fifo_empty = 1'b0;
    logic [31:0]   rd_data;
    logic [ACW-1:0] access_cycles = '0;
    logic [WW-1:0] xfer_words = '0;
    logic          cs_n, rd_n, out_valid, done, busy, underflow;
    logic [31:0]   out_data;

    int n_checks = 0, n_fail = 0, cyc = 0;
    int low_run = 0, high_run = 0, reads_seen = 0, valid_seen = 0;
    int pop_idx = 0, done_cnt = 0, exp_acc = 1, cur_exp = 0;
    bit prev_rd_n = 1'b1, finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hf_burst_drain u_hf_burst_drain (
        .clk(clk), .rst(rst), .hf_n(hf_n), .fifo_empty(fifo_empty),
        .rd_data(rd_data), .access_cycles(access_cycles), .xfer_words(xfer_words),
        .cs_n(cs_n), .rd_n(rd_n), .out_valid(out_valid), .out_data(out_data),
        .done(done), .busy(busy), .underflow(underflow)
    );

    function automatic logic [31:0] pat(input int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A_0000;
    endfunction

    assign rd_data = pat(pop_idx);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Port monitor: strobe run lengths, gaps, data order, completion
    always @(negedge clk) begin
        if (rst) begin
            prev_rd_n = 1'b1; low_run = 0; high_run = 0;
        end else begin
            if (!rd_n) begin
                if (prev_rd_n && reads_seen > 0) begin
                    if (reads_seen % 32 == 0)     chk(high_run == 13, "R6 chunk gap", high_run, 13);
                    else if (reads_seen % 8 == 0) chk(high_run == 9, "R5 burst gap", high_run, 9);
                    else                          chk(high_run == 1, "R4 access gap", high_run, 1);
                end
                if (cs_n) chk(1'b0, "R3 cs_n not paired", cs_n, 0);
                high_run = 0;
                low_run++;
            end else begin
                if (!prev_rd_n) begin
                    reads_seen++;
                    chk(low_run == exp_acc, "R3 access length", low_run, exp_acc);
                    chk(cs_n == 1'b1, "R3 cs_n release", cs_n, 1);
                    pop_idx++;
                    low_run = 0;
                end
                high_run++;
            end
            prev_rd_n = rd_n;
            if (out_valid) begin
                chk(out_data == pat(valid_seen), "R8 word data", out_data, pat(valid_seen));
                valid_seen++;
            end
            if (done) begin
                done_cnt++;
                chk(reads_seen == cur_exp && valid_seen == cur_exp, "R9 done with last word",
                    valid_seen, cur_exp);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic prep(input int acc, input int words, input int exp_words);
        @(negedge clk);
        access_cycles = ACW'(acc);
        xfer_words    = WW'(words);
        reads_seen = 0; valid_seen = 0; pop_idx = 0; done_cnt = 0;
        exp_acc = (acc == 0) ? 1 : acc;
        cur_exp = exp_words;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 60000 && done_cnt == 0; i++) @(negedge clk);
    endtask

    task automatic finish_checks(input int exp_words);
        repeat (6) @(negedge clk);
        chk(done_cnt == 1, "R2 one transfer per edge", done_cnt, 1);
        chk(reads_seen == exp_words, "R7 read count", reads_seen, exp_words);
        chk(valid_seen == exp_words, "R8 word count", valid_seen, exp_words);
        chk(!busy && cs_n && rd_n, "R11 idle strobes", {busy, cs_n, rd_n}, 3);
        hf_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_xfer(input int acc, input int words, input int exp_words);
        prep(acc, words, exp_words);
        hf_n = 1'b0;
        wait_done();
        finish_checks(exp_words);
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(cs_n && rd_n, "R1 reset strobes", {cs_n, rd_n}, 3);
        chk(!out_valid && !done && !busy && !underflow, "R1 reset flags",
            {out_valid, done, busy, underflow}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && rd_n && !busy && !done && !underflow, "R1 after reset",
            {cs_n, rd_n, busy, done, underflow}, 24);

        // Directed: single burst, chunk crossing, zero count, access 0
        run_xfer(1, 8, 8);
        run_xfer(3, 70, 70);
        run_xfer(0, 33, 33);
        run_xfer(2, 0, 0);

        // R2: hf_n high only means no start
        prep(1, 5, 0);
        repeat (10) @(negedge clk);
        chk(done_cnt == 0 && !busy, "R2 no start without edge", done_cnt, 0);

        // R2: edge while busy is ignored
        prep(2, 40, 40);
        hf_n = 1'b0;
        repeat (20) @(negedge clk);
        hf_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(busy == 1'b1, "R2 still busy", busy, 1);
        hf_n = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        finish_checks(40);

        // Random mix
        for (int k = 0; k < 6; k++) begin
            int a, w;
            a = int'($urandom % 6);
            w = 1 + int'($urandom % 100);
            run_xfer(a, w, w);
        end

        // R7: request above the clamp
        run_xfer(1, 12000, 8192);
        chk(underflow == 1'b0, "R10 no underflow yet", underflow, 0);

        // R10: empty flag during reads sets sticky error
        fifo_empty = 1'b1;
        run_xfer(1, 4, 4);
        fifo_empty = 1'b0;
        chk(underflow == 1'b1, "R10 underflow set", underflow, 1);
        run_xfer(2, 3, 3);
        chk(underflow == 1'b1, "R10 underflow sticky", underflow, 1);

        // R1: reset clears the error
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(underflow == 1'b0 && !busy && cs_n, "R1 reset clears error", underflow, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule